// File: doc/BRIEF.md
# Cascaded Segment Driver Serial Link

This block drives a chain of external segment-driver chips over a clocked serial link, one common (row) period at a time. When the row-start request is accepted, the block captures a parallel word holding one dot bit per column. It then places the bits on a serial data line one after another, highest column index first, so that the first bit travels to the far end of the chain. Every bit is clocked in by a rising edge of a shift clock. After the last bit it waits through a handover gap and then gives one pulse on a separate latch clock. That pulse makes the drivers move the shifted row onto their outputs.

The width of each clock phase, the data setup and hold windows and the handover spacing are counts of base-clock ticks, each set by a parameter. They are chosen so that the minimum times of the link are met: 800 ns per clock phase, 300 ns setup and hold, and 500 ns handover, which at 50 MHz gives 40, 15, 15 and 25 ticks. The block also drives a frame-alternation output that makes the panel drive waveform AC. This output toggles once every `FRAME_ROWS` latch pulses, and it changes on the same base-clock edge on which the latch clock rises. A busy output covers the whole sequence, from the accepted request until the latch pulse and its recovery time have ended.

The controller is a state machine with six states:
- `ST_IDLE`: waits for a request.
- `ST_SETUP`: shift clock low, data bit presented.
- `ST_SHIFT_HI`: shift clock high.
- `ST_HANDOVER`: both clocks low after the last bit.
- `ST_LATCH_HI`: latch clock high.
- `ST_RECOVER`: latch clock low before the next row may begin.

Its transitions are:
- idle to setup, on an accepted request.
- setup to shift-high, when the setup time has run out.
- shift-high to setup, when more bits remain.
- shift-high to handover, after the last bit.
- handover to latch-high.
- latch-high to recover.
- recover to idle.

Each of these, apart from idle to setup, happens when the phase timer for the current state expires.

Top module: `seg_serial_link`

## Requirements
- R1: After reset, and while reset is held, `sclk`, `lclk`, `sdata`, `alt` and `busy` are all 0, and the frame latch count is cleared.
- R2: A `row_start` sampled high while idle makes `busy` high from the next cycle. `busy` stays high for exactly NCOL*(LOW_T+HIGH_T)+HAND_T+PHASE_T+TAIL_T cycles and then falls, where LOW_T=max(PHASE_T,SETUP_T), HIGH_T=max(PHASE_T,HOLD_T) and TAIL_T=max(PHASE_T,HAND_T).
- R3: Each row gives exactly NCOL rising edges of `sclk`. On the k-th rising edge (k from 0) `sdata` equals `row_bits[NCOL-1-k]`, where 1 means a selected dot and 0 a non-selected dot.
- R4: `sclk` is high for exactly HIGH_T cycles and low for at least LOW_T cycles before each rise. `sdata` is stable for at least LOW_T cycles before each `sclk` rise and does not change while `sclk` is high.
- R5: Each row gives exactly one `lclk` pulse, HIGH for exactly PHASE_T cycles. It rises exactly HAND_T cycles after the last `sclk` fall.
- R6: `sclk` and `lclk` are never high together, and no `sclk` rise happens within TAIL_T cycles after an `lclk` fall.
- R7: `alt` toggles on every FRAME_ROWS-th `lclk` pulse counted since reset. It changes only in the cycle in which `lclk` rises.
- R8: A `row_start` asserted while `busy` is high is ignored. The row in progress, its length and its single latch pulse are unchanged.
- R9: `row_bits` is sampled only when a request is accepted. Later changes do not alter the bits being shifted.
- R10: `sdata` is 0 whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_start | input | 1 | Request to send one row (sampled while idle) |
| row_bits | input | NCOL | Dot pattern of the row, 1 = selected |
| sclk | output | 1 | Shift clock to the drivers, data taken on rising edge |
| lclk | output | 1 | Latch clock to the drivers |
| sdata | output | 1 | Serial dot data |
| alt | output | 1 | Frame alternation signal for AC drive |
| busy | output | 1 | High while a row is being sent and latched |

## Verification
The embedded properties check the following on every cycle:
- the two clocks never overlap;
- serial data does not move while the shift clock is high, nor on the edge that raises it;
- the shift-clock high width;
- the latch never rises straight out of a shift pulse;
- the alternation output moves only with a latch rising edge;
- the serial line is quiet while idle.

Only the bench scenarios can show the following:
- the bit order and the captured values;
- the exact row length seen on `busy`;
- the handover spacing;
- that a request during a busy row is dropped;
- that late changes on the pattern input are ignored;
- the frame count at which `alt` toggles.

// File: rtl/seg_link_pkg.sv
package seg_link_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT_HI,
        ST_HANDOVER,
        ST_LATCH_HI,
        ST_RECOVER
    } link_state_t;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seg_link_timer.sv
module seg_link_timer #(
    parameter int unsigned W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    // R2: a phase interval never reloads beyond its programmed value range
    assert_timer_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load) |-> (cnt == $past(load_val)));

endmodule

// File: rtl/seg_link_shifter.sv
module seg_link_shifter #(
    parameter int unsigned NCOL = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            shift,
    input  logic            clear,
    input  logic [NCOL-1:0] din,
    output logic            sout,
    output logic            last
);
    localparam int unsigned IW = (NCOL > 1) ? $clog2(NCOL) : 1;

    logic [NCOL-1:0] shreg;
    logic [IW-1:0]   idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            idx   <= '0;
        end else if (clear) begin
            shreg <= '0;
            idx   <= '0;
        end else if (load) begin
            shreg <= din;
            idx   <= '0;
        end else if (shift) begin
            shreg <= {shreg[NCOL-2:0], 1'b0};
            idx   <= idx + 1'b1;
        end
    end

    assign sout = shreg[NCOL-1];
    assign last = (idx == IW'(NCOL - 1));

    // R3: the controller never asks for a bit beyond the row width
    assert_no_overshift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        shift |-> !last);

endmodule

// File: rtl/seg_link_frame.sv
module seg_link_frame #(
    parameter int unsigned FRAME_ROWS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic latch_evt,
    output logic alt
);
    localparam int unsigned CW = $clog2(FRAME_ROWS + 1);

    logic [CW-1:0] rows;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rows <= '0;
            alt  <= 1'b0;
        end else if (latch_evt) begin
            if (rows == CW'(FRAME_ROWS - 1)) begin
                rows <= '0;
                alt  <= ~alt;
            end else begin
                rows <= rows + 1'b1;
            end
        end
    end

    // R7: the latch count stays inside one frame
    assert_frame_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rows < CW'(FRAME_ROWS));

endmodule

// File: rtl/seg_serial_link.sv
module seg_serial_link
    import seg_link_pkg::*;
#(
    parameter int unsigned NCOL       = 40,
    parameter int unsigned PHASE_T    = 40,
    parameter int unsigned SETUP_T    = 15,
    parameter int unsigned HOLD_T     = 15,
    parameter int unsigned HAND_T     = 25,
    parameter int unsigned FRAME_ROWS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            row_start,
    input  logic [NCOL-1:0] row_bits,
    output logic            sclk,
    output logic            lclk,
    output logic            sdata,
    output logic            alt,
    output logic            busy
);
    localparam int unsigned LOW_T  = umax(PHASE_T, SETUP_T);
    localparam int unsigned HIGH_T = umax(PHASE_T, HOLD_T);
    localparam int unsigned GAP_T  = HAND_T;
    localparam int unsigned TAIL_T = umax(PHASE_T, HAND_T);
    localparam int unsigned MAX_T  = umax(umax(LOW_T, HIGH_T), umax(GAP_T, TAIL_T));
    localparam int unsigned TW     = $clog2(MAX_T + 1);

    link_state_t state, state_nxt;

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_exp;
    logic          sh_load, sh_shift, sh_clear, sh_last;
    logic          frame_evt;

    seg_link_timer #(.W(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_exp)
    );

    seg_link_shifter #(.NCOL(NCOL)) u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .load (sh_load),
        .shift(sh_shift),
        .clear(sh_clear),
        .din  (row_bits),
        .sout (sdata),
        .last (sh_last)
    );

    seg_link_frame #(.FRAME_ROWS(FRAME_ROWS)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .latch_evt(frame_evt),
        .alt      (alt)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // next state and datapath controls
    always_comb begin
        state_nxt = state;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        sh_load   = 1'b0;
        sh_shift  = 1'b0;
        sh_clear  = 1'b0;
        frame_evt = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (row_start) begin
                    state_nxt = ST_SETUP;
                    tmr_load  = 1'b1;
                    tmr_val   = TW'(LOW_T - 1);
                    sh_load   = 1'b1;
                end
            end
            ST_SETUP: begin
                if (tmr_exp) begin
                    state_nxt = ST_SHIFT_HI;
                    tmr_load  = 1'b1;
                    tmr_val   = TW'(HIGH_T - 1);
                end
            end
            ST_SHIFT_HI: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    if (sh_last) begin
                        state_nxt = ST_HANDOVER;
                        tmr_val   = TW'(GAP_T - 1);
                    end else begin
                        state_nxt = ST_SETUP;
                        tmr_val   = TW'(LOW_T - 1);
                        sh_shift  = 1'b1;
                    end
                end
            end
            ST_HANDOVER: begin
                if (tmr_exp) begin
                    state_nxt = ST_LATCH_HI;
                    tmr_load  = 1'b1;
                    tmr_val   = TW'(PHASE_T - 1);
                    frame_evt = 1'b1;
                end
            end
            ST_LATCH_HI: begin
                if (tmr_exp) begin
                    state_nxt = ST_RECOVER;
                    tmr_load  = 1'b1;
                    tmr_val   = TW'(TAIL_T - 1);
                end
            end
            ST_RECOVER: begin
                if (tmr_exp) begin
                    state_nxt = ST_IDLE;
                    sh_clear  = 1'b1;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk <= 1'b0;
            lclk <= 1'b0;
            busy <= 1'b0;
        end else begin
            sclk <= (state_nxt == ST_SHIFT_HI);
            lclk <= (state_nxt == ST_LATCH_HI);
            busy <= (state_nxt != ST_IDLE);
        end
    end

    // width monitor for the shift-clock high phase
    logic [TW:0] hi_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    hi_run <= '0;
        else if (sclk) hi_run <= hi_run + 1'b1;
        else           hi_run <= '0;
    end

    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(sclk && lclk));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdata));

    assert_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(sdata));

    assert_hi_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> (hi_run == (TW+1)'(HIGH_T)));

    assert_clk_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk || lclk) |-> busy);

    assert_latch_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lclk) |-> !$past(sclk));

    assert_alt_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (alt != $past(alt)) |-> $rose(lclk));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sdata);

endmodule

// File: tb/sim_seg_serial_link.sv
module sim_seg_serial_link;
    localparam int NC    = 8;
    localparam int PH    = 3;
    localparam int SU    = 4;
    localparam int HO    = 2;
    localparam int HD    = 5;
    localparam int FR    = 3;
    localparam int LOW_T  = (PH > SU) ? PH : SU;
    localparam int HIGH_T = (PH > HO) ? PH : HO;
    localparam int TAIL_T = (PH > HD) ? PH : HD;
    localparam int EXP_BUSY = NC * (LOW_T + HIGH_T) + HD + PH + TAIL_T;

    // {expected alt after the row, pattern}
    localparam logic [8:0] VEC [6] = '{9'h0A5, 9'h0FF, 9'h100, 9'h181, 9'h13C, 9'h001};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic row_start = 1'b0;
    logic [NC-1:0] row_bits = '0;
    logic sclk, lclk, sdata, alt, busy;

    always #10 clk = ~clk;

    seg_serial_link #(
        .NCOL(NC), .PHASE_T(PH), .SETUP_T(SU), .HOLD_T(HO),
        .HAND_T(HD), .FRAME_ROWS(FR)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .row_start(row_start), .row_bits(row_bits),
        .sclk(sclk), .lclk(lclk), .sdata(sdata), .alt(alt), .busy(busy)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor, sampling on the falling edge
    int rises = 0, lats = 0;
    logic [NC-1:0] cap = '0;
    logic p_sclk = 0, p_lclk = 0, p_alt = 0, p_sdata = 0;
    int hi_run = 0, lo_run = 0, sd_run = 0, lhi_run = 0;
    int since_sfall = 1000, since_lfall = 1000;
    int min_hi = 1000, max_hi = 0, min_lo = 1000, min_setup = 1000;
    int min_gap = 1000, max_gap = 0, min_lw = 1000, max_lw = 0, min_tail = 1000;
    int hold_bad = 0, overlap = 0, alt_bad = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            hi_run = 0; lo_run = 0; sd_run = 0; lhi_run = 0;
            since_sfall = 1000; since_lfall = 1000;
        end else begin
            if (sdata == p_sdata) sd_run++; else sd_run = 0;
            if (sclk && !p_sclk) begin
                rises++;
                cap = {cap[NC-2:0], sdata};
                if (lo_run < min_lo) min_lo = lo_run;
                if (sd_run < min_setup) min_setup = sd_run;
                if (since_lfall < min_tail) min_tail = since_lfall;
            end
            if (!sclk && p_sclk) begin
                if (hi_run < min_hi) min_hi = hi_run;
                if (hi_run > max_hi) max_hi = hi_run;
            end
            if (sclk && p_sclk && sdata != p_sdata) hold_bad++;
            if (lclk && !p_lclk) begin
                lats++;
                if (since_sfall < min_gap) min_gap = since_sfall;
                if (since_sfall > max_gap) max_gap = since_sfall;
            end
            if (!lclk && p_lclk) begin
                if (lhi_run < min_lw) min_lw = lhi_run;
                if (lhi_run > max_lw) max_lw = lhi_run;
            end
            if (sclk && lclk) overlap++;
            if (alt != p_alt && !(lclk && !p_lclk)) alt_bad++;
            hi_run  = sclk ? hi_run + 1 : 0;
            lo_run  = sclk ? 0 : lo_run + 1;
            lhi_run = lclk ? lhi_run + 1 : 0;
            if (!sclk && p_sclk) since_sfall = 1; else since_sfall++;
            if (!lclk && p_lclk) since_lfall = 1; else since_lfall++;
        end
        p_sclk = sclk; p_lclk = lclk; p_alt = alt; p_sdata = sdata;
    end

    int n_lat = 0;

    task automatic run_row(input logic [NC-1:0] p, input bit inject, input bit exp_alt);
        int r0, l0, cnt;
        r0 = rises; l0 = lats;
        @(posedge clk); #1;
        row_bits = p; row_start = 1'b1;
        @(posedge clk); #1;
        row_start = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R2 busy after request", int'(busy), 1);
        cnt = 0;
        do begin
            if (busy) cnt++;
            if (inject && cnt == 20) begin row_start = 1'b1; row_bits = ~p; end
            if (inject && cnt == 21) row_start = 1'b0;
            if (inject && cnt == 30) row_bits = ~p; // R9 late change
            @(negedge clk);
        end while (busy && cnt < 2000);
        row_start = 1'b0;
        n_lat++;
        chk(cnt == EXP_BUSY, inject ? "R8 busy length" : "R2 busy length", cnt, EXP_BUSY);
        chk(rises - r0 == NC, "R3 shift edges", rises - r0, NC);
        chk(cap == p, inject ? "R9 captured row" : "R3 captured row", int'(cap), int'(p));
        chk(lats - l0 == 1, inject ? "R8 latch count" : "R5 latch count", lats - l0, 1);
        chk(sdata == 1'b0, "R10 idle data", int'(sdata), 0);
        chk(alt == exp_alt, "R7 alt level", int'(alt), int'(exp_alt));
        repeat (2) @(negedge clk);
        chk(busy == 1'b0 && sclk == 1'b0, "R8 stays idle", int'(busy), 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({sclk, lclk, sdata, alt, busy} == 5'b0, "R1 reset outputs",
            int'({sclk, lclk, sdata, alt, busy}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 idle after reset", int'(busy), 0);

        for (int i = 0; i < 6; i++)
            run_row(VEC[i][7:0], 1'b0, VEC[i][8]);

        chk(min_hi == HIGH_T && max_hi == HIGH_T, "R4 sclk high width", min_hi, HIGH_T);
        chk(min_lo >= LOW_T, "R4 sclk low width", min_lo, LOW_T);
        chk(min_setup >= LOW_T, "R4 data setup", min_setup, LOW_T);
        chk(hold_bad == 0, "R4 data hold", hold_bad, 0);
        chk(min_gap == HD && max_gap == HD, "R5 handover gap", min_gap, HD);
        chk(min_lw == PH && max_lw == PH, "R5 latch width", min_lw, PH);
        chk(overlap == 0, "R6 clock overlap", overlap, 0);
        chk(min_tail >= TAIL_T, "R6 latch to shift spacing", min_tail, TAIL_T);
        chk(alt_bad == 0, "R7 alt alignment", alt_bad, 0);

        // R8 and R9: request and pattern change during a busy row
        run_row(8'hC6, 1'b1, ((n_lat + 1) / FR) % 2 == 1);
        run_row(8'h5A, 1'b0, ((n_lat + 1) / FR) % 2 == 1);
        run_row(8'h80, 1'b0, ((n_lat + 1) / FR) % 2 == 1);
        chk(alt == 1'b1, "R7 alt after nine latches", int'(alt), 1);

        // R1 reset in the middle of a row
        @(posedge clk); #1; row_bits = 8'hF0; row_start = 1'b1;
        @(posedge clk); #1; row_start = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk({sclk, lclk, sdata, alt, busy} == 5'b0, "R1 mid-row reset",
            int'({sclk, lclk, sdata, alt, busy}), 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        n_lat = 0;
        repeat (2) @(negedge clk);
        run_row(8'h33, 1'b0, 1'b0);
        run_row(8'hE1, 1'b0, 1'b0);
        run_row(8'h7E, 1'b0, 1'b1);
        chk(alt_bad == 0, "R7 alt alignment after reset", alt_bad, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule